// File: doc/BRIEF.md
# FEAC Receive Codeword Validator

This block watches the far-end alarm and control bit that an upstream DS3 framer pulls out of each incoming frame. The bit arrives one per strobe. The block hunts for the message alignment pattern, which is a zero followed by eight ones. It captures the six-bit codeword that comes right after the pattern, and it keeps a sliding record of the most recent messages.

A codeword becomes validated when it takes a clear majority of the recent messages. Once validated, it is withdrawn when enough disagreeing messages arrive. Each of these two decisions raises a sticky status bit. A read strobe clears the status bits. An interrupt line follows the status bits, but only while both interrupt enables are set. Software sees the two enables and the two status bits side by side in one four-bit status word.

Top module: `feac_rx_validator`

## Requirements
- R1: A message starts only after the nine most recent strobed bits were a zero followed by eight ones. Bits presented while `feac_bit_vld` is low are ignored and do not break or form the pattern.
- R2: The six strobed bits after the pattern form the codeword. The first of them is bit 5 (MSB) and the last is bit 0.
- R3: Bits that never complete the alignment pattern add no message. The validated state, the codeword output and the status bits are left unchanged.
- R4: While nothing is validated, a message whose codeword matches at least 8 of the last 10 messages (counting itself) sets `code_valid_o`. It also drives that codeword on `code_o` and sets the validation status bit. At 7 of 10 nothing happens.
- R5: While a codeword is validated, a message that leaves at least 3 of the last 10 messages different from it sets the removal status bit and clears `code_valid_o`. At 2 of 10 the codeword stays validated.
- R6: After a removal, a codeword is validated again only once it reaches 8 of the last 10 messages. `code_o` keeps the last validated value meanwhile.
- R7: `irq_o` is high exactly when both `ien_valid` and `ien_remove` are high and at least one status bit is set.
- R8: `stat_reg_o` packs the status word as follows:
  - bit 0 is `ien_valid`
  - bit 1 is `ien_remove`
  - bit 2 is the validation status bit
  - bit 3 is the removal status bit
- R9: A cycle with `stat_rd` high clears both status bits. An event decided in that same cycle still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feac_bit | input | 1 | Serial FEAC bit from the frame |
| feac_bit_vld | input | 1 | Strobe qualifying `feac_bit` |
| ien_valid | input | 1 | Validation interrupt enable |
| ien_remove | input | 1 | Removal interrupt enable |
| stat_rd | input | 1 | Status read; clears status bits |
| code_o | output | 6 | Last validated codeword |
| code_valid_o | output | 1 | A codeword is currently validated |
| stat_reg_o | output | 4 | Enables and status bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench interleaves dead cycles that carry the inverse bit into the stream. A design that sampled without the strobe would lose alignment and never validate. A decoy of a zero and only seven ones comes just before a real pattern, so a matcher that is one bit short would fire early and capture a shifted codeword. The codeword is asymmetric, so a design that assembles bits LSB-first would report a different value.

The counts are driven to their edges: 7 versus 8 for validation, and 2 versus 3 for removal. Off-by-one thresholds, or windows that count stale or empty entries, show up as a validation or removal one message too early or too late. A read held high across the deciding cycle catches a design where clear beats set, because that design would lose the event.

// File: rtl/feac_pkg.sv
package feac_pkg;

    localparam int FEAC_CW = 6;

    typedef logic [FEAC_CW-1:0] feac_code_t;

    typedef struct packed {
        logic       vld;
        feac_code_t code;
    } feac_msg_t;

    typedef enum logic {
        FR_HUNT    = 1'b0,
        FR_CAPTURE = 1'b1
    } feac_fr_state_e;

    // Alignment pattern: a zero then ONES ones, newest bit at position 0
    function automatic logic [15:0] align_pattern(input int ones);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < ones) p[i] = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/feac_framer.sv
module feac_framer
    import feac_pkg::*;
#(
    parameter int ONES = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_in,
    input  logic      bit_vld,
    output feac_msg_t msg
);
    localparam int PW   = ONES + 1;
    localparam int CNTW = $clog2(FEAC_CW);
    localparam logic [PW-1:0] PAT = PW'(align_pattern(ONES));

    feac_fr_state_e  state_q;
    logic [PW-1:0]   win_q;
    logic [PW-1:0]   win_nxt;
    logic [CNTW-1:0] cnt_q;
    feac_code_t      sh_q;
    feac_code_t      sh_nxt;

    assign win_nxt = {win_q[PW-2:0], bit_in};
    assign sh_nxt  = {sh_q[FEAC_CW-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FR_HUNT;
            win_q    <= '1;
            cnt_q    <= '0;
            sh_q     <= '0;
            msg      <= '0;
        end else begin
            msg.vld <= 1'b0;
            if (bit_vld) begin
                unique case (state_q)
                    FR_HUNT: begin
                        if (win_nxt == PAT) begin
                            state_q <= FR_CAPTURE;
                            cnt_q   <= '0;
                            win_q   <= '1;
                        end else begin
                            win_q   <= win_nxt;
                        end
                    end
                    FR_CAPTURE: begin
                        sh_q  <= sh_nxt;
                        cnt_q <= cnt_q + CNTW'(1);
                        if (cnt_q == CNTW'(FEAC_CW - 1)) begin
                            msg.vld  <= 1'b1;
                            msg.code <= sh_nxt;
                            state_q  <= FR_HUNT;
                        end
                    end
                    default: state_q <= FR_HUNT;
                endcase
            end
        end
    end

    // R2
    msg_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        msg.vld |-> $past(bit_vld));

    // R1
    msg_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        msg.vld |=> !msg.vld);

endmodule

// File: rtl/feac_history.sv
module feac_history
    import feac_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  feac_msg_t                   msg,
    input  feac_code_t                  ref_code,
    output logic [$clog2(DEPTH+1)-1:0]  cnt_same,
    output logic [$clog2(DEPTH+1)-1:0]  cnt_other
);
    localparam int SD   = DEPTH - 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [SD-1:0][FEAC_CW-1:0] hist_q;
    logic [SD-1:0]              hv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            hv_q   <= '0;
        end else if (msg.vld) begin
            hist_q <= {hist_q[SD-2:0], msg.code};
            hv_q   <= {hv_q[SD-2:0], 1'b1};
        end
    end

    // Window = incoming codeword plus the SD stored ones
    always_comb begin
        cnt_same  = CNTW'(1);
        cnt_other = (msg.code != ref_code) ? CNTW'(1) : '0;
        for (int k = 0; k < SD; k++) begin
            if (hv_q[k]) begin
                if (hist_q[k] == msg.code) cnt_same  = cnt_same + CNTW'(1);
                if (hist_q[k] != ref_code) cnt_other = cnt_other + CNTW'(1);
            end
        end
    end

    // R3
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(msg.vld) |-> ($stable(hist_q) && $stable(hv_q)));

endmodule

// File: rtl/feac_status.sv
module feac_status
    import feac_pkg::*;
#(
    parameter int DEPTH   = 10,
    parameter int VAL_THR = 8,
    parameter int REM_THR = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  feac_msg_t                  msg,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_same,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_other,
    input  logic                       ien_valid,
    input  logic                       ien_remove,
    input  logic                       stat_rd,
    output feac_code_t                 vcode,
    output logic                       validated,
    output logic [3:0]                 stat_reg,
    output logic                       irq
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic st_val_q;
    logic st_rem_q;
    logic evt_val;
    logic evt_rem;

    assign evt_val = msg.vld && !validated && (cnt_same  >= CNTW'(VAL_THR));
    assign evt_rem = msg.vld &&  validated && (cnt_other >= CNTW'(REM_THR));

    always_ff @(posedge clk) begin
        if (rst) begin
            validated <= 1'b0;
            vcode     <= '0;
            st_val_q  <= 1'b0;
            st_rem_q  <= 1'b0;
        end else begin
            if (evt_val) begin
                validated <= 1'b1;
                vcode     <= msg.code;
            end else if (evt_rem) begin
                validated <= 1'b0;
            end
            st_val_q <= evt_val | (st_val_q & ~stat_rd);
            st_rem_q <= evt_rem | (st_rem_q & ~stat_rd);
        end
    end

    assign stat_reg = {st_rem_q, st_val_q, ien_remove, ien_valid};
    assign irq      = ien_valid & ien_remove & (st_val_q | st_rem_q);

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_valid && ien_remove));

    // R4
    val_sets_stat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(validated) |-> st_val_q);

    // R5
    rem_sets_stat_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(validated) |-> st_rem_q);

    // R6
    state_on_msg_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(msg.vld) |-> ($stable(validated) && $stable(vcode)));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !msg.vld) |=> (!st_val_q && !st_rem_q));

endmodule

// File: rtl/feac_rx_validator.sv
module feac_rx_validator
    import feac_pkg::*;
#(
    parameter int ONES    = 8,
    parameter int DEPTH   = 10,
    parameter int VAL_THR = 8,
    parameter int REM_THR = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       feac_bit,
    input  logic       feac_bit_vld,
    input  logic       ien_valid,
    input  logic       ien_remove,
    input  logic       stat_rd,
    output logic [5:0] code_o,
    output logic       code_valid_o,
    output logic [3:0] stat_reg_o,
    output logic       irq_o
);
    localparam int CNTW = $clog2(DEPTH + 1);

    feac_msg_t       msg;
    feac_code_t      vcode;
    logic [CNTW-1:0] cnt_same;
    logic [CNTW-1:0] cnt_other;

    feac_framer #(.ONES(ONES)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (feac_bit),
        .bit_vld (feac_bit_vld),
        .msg     (msg)
    );

    feac_history #(.DEPTH(DEPTH)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .msg       (msg),
        .ref_code  (vcode),
        .cnt_same  (cnt_same),
        .cnt_other (cnt_other)
    );

    feac_status #(
        .DEPTH   (DEPTH),
        .VAL_THR (VAL_THR),
        .REM_THR (REM_THR)
    ) u_stat (
        .clk        (clk),
        .rst        (rst),
        .msg        (msg),
        .cnt_same   (cnt_same),
        .cnt_other  (cnt_other),
        .ien_valid  (ien_valid),
        .ien_remove (ien_remove),
        .stat_rd    (stat_rd),
        .vcode      (vcode),
        .validated  (code_valid_o),
        .stat_reg   (stat_reg_o),
        .irq        (irq_o)
    );

    assign code_o = vcode;

endmodule

// File: tb/tb_feac_rx_validator.sv
module tb_feac_rx_validator;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       feac_bit = 1'b0;
    logic       feac_bit_vld = 1'b0;
    logic       ien_valid = 1'b0;
    logic       ien_remove = 1'b0;
    logic       stat_rd = 1'b0;
    logic [5:0] code_o;
    logic       code_valid_o;
    logic [3:0] stat_reg_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;

    localparam logic [5:0] CODE_A = 6'h0B;
    localparam logic [5:0] CODE_B = 6'h30;

    always #2 clk = ~clk;

    feac_rx_validator dut (
        .clk          (clk),
        .rst          (rst),
        .feac_bit     (feac_bit),
        .feac_bit_vld (feac_bit_vld),
        .ien_valid    (ien_valid),
        .ien_remove   (ien_remove),
        .stat_rd      (stat_rd),
        .code_o       (code_o),
        .code_valid_o (code_valid_o),
        .stat_reg_o   (stat_reg_o),
        .irq_o        (irq_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b, bit gap);
        if (gap) begin
            @(negedge clk);
            feac_bit     = ~b;
            feac_bit_vld = 1'b0;
        end
        @(negedge clk);
        feac_bit     = b;
        feac_bit_vld = 1'b1;
    endtask

    task automatic send_msg(logic [5:0] code, bit gap, bit hold_rd);
        send_bit(1'b0, gap);
        for (int i = 0; i < 8; i++) send_bit(1'b1, gap);
        for (int i = 5; i >= 0; i--) send_bit(code[i], gap);
        @(negedge clk);
        feac_bit_vld = 1'b0;
        if (hold_rd) begin
            @(negedge clk);
            stat_rd = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic read_status();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset status word", 32'(stat_reg_o), 32'h0);
        chk("R7 reset irq", 32'(irq_o), 32'h0);
        chk("R4 reset valid", 32'(code_valid_o), 32'h0);
    endtask

    task automatic t_validate();
        ien_valid  = 1'b1;
        ien_remove = 1'b1;
        for (int n = 0; n < 7; n++) send_msg(CODE_A, n[0], 1'b0);
        chk("R4 seven of ten not validated", 32'(code_valid_o), 32'h0);
        chk("R4 no status at seven", 32'(stat_reg_o), 32'h3);
        send_msg(CODE_A, 1'b1, 1'b0);
        chk("R4 validated at eight", 32'(code_valid_o), 32'h1);
        chk("R2 codeword MSB first", 32'(code_o), 32'(CODE_A));
        chk("R8 status word after validation", 32'(stat_reg_o), 32'h7);
        chk("R7 irq with both enables", 32'(irq_o), 32'h1);
    endtask

    task automatic t_clear();
        read_status();
        chk("R9 read clears status", 32'(stat_reg_o), 32'h3);
        chk("R7 irq drops after read", 32'(irq_o), 32'h0);
    endtask

    task automatic t_noise();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            feac_bit     = 1'b1;
            feac_bit_vld = 1'b1;
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            feac_bit     = i[0];
            feac_bit_vld = 1'b0;
        end
        @(negedge clk);
        feac_bit_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 noise leaves valid", 32'(code_valid_o), 32'h1);
        chk("R3 noise leaves status", 32'(stat_reg_o), 32'h3);
        chk("R3 noise leaves code", 32'(code_o), 32'(CODE_A));
    endtask

    task automatic t_remove();
        // decoy: zero then only seven ones must not align
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
        send_msg(CODE_B, 1'b0, 1'b0);
        send_msg(CODE_B, 1'b1, 1'b0);
        chk("R5 two of ten keeps validation", 32'(code_valid_o), 32'h1);
        chk("R5 no removal at two", 32'(stat_reg_o), 32'h3);
        send_msg(CODE_B, 1'b0, 1'b0);
        chk("R5 removal at three", 32'(code_valid_o), 32'h0);
        chk("R5 removal status word", 32'(stat_reg_o), 32'hB);
        chk("R6 code held after removal", 32'(code_o), 32'(CODE_A));
        chk("R1 decoy did not shift codeword", 32'(code_o), 32'(CODE_A));
        read_status();
    endtask

    task automatic t_revalidate();
        for (int n = 0; n < 7; n++) begin
            send_msg(CODE_A, 1'b0, 1'b0);
            chk("R6 not revalidated below eight", 32'(code_valid_o), 32'h0);
        end
        stat_rd = 1'b1;
        send_msg(CODE_A, 1'b1, 1'b1);
        chk("R6 revalidated at eight", 32'(code_valid_o), 32'h1);
        chk("R9 event wins over same-cycle read", 32'(stat_reg_o), 32'h7);
    endtask

    task automatic t_enables();
        ien_remove = 1'b0;
        @(negedge clk);
        chk("R7 irq masked by one enable", 32'(irq_o), 32'h0);
        chk("R8 enable bit reflects input", 32'(stat_reg_o), 32'h5);
        ien_remove = 1'b1;
        ien_valid  = 1'b0;
        @(negedge clk);
        chk("R7 irq masked by other enable", 32'(irq_o), 32'h0);
        ien_valid = 1'b1;
        @(negedge clk);
        chk("R7 irq with both enables again", 32'(irq_o), 32'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_validate();
        t_clear();
        t_noise();
        t_remove();
        t_revalidate();
        t_enables();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule